// File: doc/BRIEF.md
# DS2 Frame and Multiframe Aligner

This block takes a serial DS2 bit stream in the four-tributary multiplex format, one bit per clock, and finds where the frame and the multiframe start. The stream is built from 49-bit blocks. The first bit of each block is an overhead bit. There are six blocks in a subframe and four subframes in a multiframe, for 1176 bits. The aligner first looks for framing bits at the overhead positions of the third and sixth blocks. These bits are 147 bits apart and alternate 0, 1. Once it has frame, it uses the overhead bits of the first blocks to fix which subframe is which.

After alignment the block gives a bit, block and subframe position for the bit that is on the input at that moment. It also gives an in-frame flag, a multiframe-aligned flag and the spare overhead bit latched in subframe 3. For each tributary it gives a stuff decision, taken as a majority vote over that subframe's three stuff-control bits. A downstream demultiplexer uses these to route tributary bits and to drop stuff bits.

Top module: `ds2_aligner`

## Requirements
- R1: After reset `bit_pos`, `blk_pos`, `sf_pos`, `in_frame`, `mf_aligned`, `x_bit` and `stuff` are all zero. While aligned, `bit_pos` counts 0..48 and then wraps, advancing `blk_pos` (0..5). `blk_pos` wrapping advances `sf_pos` (0..3). All positions describe the bit currently on `rx_bit`.
- R2: Framing bits sit at `bit_pos`=0 with `blk_pos`=2, which carries 0, and `blk_pos`=5, which carries 1. `in_frame` rises in the cycle after the tenth consecutive framing bit that fits the pattern is sampled.
- R3: During search, the first framing bit of a trial is accepted with either value, and the block count is re-aimed to match it. Any later mismatch moves the candidate phase one bit later and restarts the count.
- R4: Once `in_frame` is high, `bit_pos` and `blk_pos` equal the true position of the bit on `rx_bit`.
- R5: While in frame, `in_frame` and `mf_aligned` fall in the cycle after a framing bit that leaves 2 errors among the last 4 framing bits. One error between runs of correct framing bits keeps frame.
- R6: After loss of frame the search restarts at the current phase. On a correctly phased stream, frame returns after 10 more framing bits.
- R7: Once in frame, three successive block-0 overhead bits reading 0, 1, 1 set `mf_aligned`. From then on `sf_pos` matches the subframe number, where the 0, 1, 1 bits are in subframes 0, 1, 2 and the spare bit is in subframe 3. The spare bit may take either value.
- R8: While multiframe aligned, `x_bit` takes the overhead bit at `blk_pos`=0 of subframe 3 once per multiframe.
- R9: For subframe n, `stuff[n]` becomes the majority of the overhead bits at `blk_pos` 1, 3 and 4 of that subframe. It is valid by the time `blk_pos`=5, `bit_pos`=0 is on the input.
- R10: `mf_aligned` is never high without `in_frame`. `stuff` and `x_bit` stay unchanged while `mf_aligned` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial DS2 data, one bit per clock |
| bit_pos | output | 6 | Bit index inside the block (0 = overhead bit) |
| blk_pos | output | 3 | Block index inside the subframe |
| sf_pos | output | 2 | Subframe index inside the multiframe |
| in_frame | output | 1 | Frame alignment held |
| mf_aligned | output | 1 | Multiframe alignment held |
| x_bit | output | 1 | Latched spare overhead bit |
| stuff | output | 4 | Per-tributary stuff decision, bit n for subframe n |

## Verification
A wrong bit or block count appears at once as position outputs that differ from the generated stream. It also shows as a framing error every 147 bits, so a bad phase that survives lock drops frame within two or three framing bits. A wrong lock count moves the rise of `in_frame` by a multiple of 147 cycles, and the bench samples that rise on its exact cycle. A misread subframe phase shows as `sf_pos` out of step and as stuff or spare-bit values put on the wrong tributary or read from the wrong bits. Each of these appears within one multiframe.

// File: rtl/ds2_aligner.sv
module ds2_aligner #(
  parameter int BLK_BITS   = 49,
  parameter int BLKS       = 6,
  parameter int SUBFRAMES  = 4,
  parameter int LOCK_COUNT = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  output logic [5:0] bit_pos,
  output logic [2:0] blk_pos,
  output logic [1:0] sf_pos,
  output logic       in_frame,
  output logic       mf_aligned,
  output logic       x_bit,
  output logic [3:0] stuff
);
  localparam int CW = $clog2(LOCK_COUNT + 1);
  localparam logic [2:0] BLK_F0 = 3'd2;
  localparam logic [2:0] BLK_F1 = 3'(BLKS - 1);
  localparam logic [2:0] BLK_C1 = 3'd1;
  localparam logic [2:0] BLK_C2 = 3'd3;
  localparam logic [2:0] BLK_C3 = 3'd4;
  localparam logic [1:0] SF_X   = 2'(SUBFRAMES - 1);

  logic [CW-1:0] hits;
  logic [2:0]    ferr;
  logic [1:0]    mhist;
  logic          c1, c2;

  logic oh, f_slot, f_bad, slip, swap, bit_last, blk_last, lof, mf_hit;

  assign oh       = bit_pos == 6'd0;
  assign f_slot   = oh && (blk_pos == BLK_F0 || blk_pos == BLK_F1);
  assign f_bad    = rx_bit != (blk_pos == BLK_F1);
  assign slip     = !in_frame && f_slot && f_bad && hits != '0;
  assign swap     = !in_frame && f_slot && f_bad && hits == '0;
  assign bit_last = bit_pos == 6'(BLK_BITS - 1);
  assign blk_last = blk_pos == BLK_F1;
  assign lof      = in_frame && f_slot && ($countones({ferr, f_bad}) >= 2);
  assign mf_hit   = in_frame && !mf_aligned && oh && blk_pos == 3'd0
                    && {mhist, rx_bit} == 3'b011;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_pos <= '0;
      blk_pos <= '0;
      sf_pos  <= '0;
    end else if (slip) begin
      bit_pos <= bit_pos;
    end else if (swap) begin
      bit_pos <= 6'd1;
      blk_pos <= (blk_pos == BLK_F0) ? BLK_F1 : BLK_F0;
    end else begin
      bit_pos <= bit_last ? '0 : bit_pos + 6'd1;
      if (bit_last) begin
        blk_pos <= blk_last ? '0 : blk_pos + 3'd1;
        if (blk_last)
          sf_pos <= (sf_pos == SF_X) ? '0 : sf_pos + 2'd1;
      end
      if (mf_hit)
        sf_pos <= SF_X - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hits     <= '0;
      in_frame <= 1'b0;
      ferr     <= '0;
    end else if (!in_frame) begin
      ferr <= '0;
      if (f_slot) begin
        if (slip) begin
          hits <= '0;
        end else if (hits == CW'(LOCK_COUNT - 1)) begin
          hits     <= '0;
          in_frame <= 1'b1;
        end else begin
          hits <= hits + 1'b1;
        end
      end
    end else if (f_slot) begin
      ferr <= {ferr[1:0], f_bad};
      if (lof)
        in_frame <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mf_aligned <= 1'b0;
      mhist      <= 2'b11;
    end else if (!in_frame || lof) begin
      mf_aligned <= 1'b0;
      mhist      <= 2'b11;
    end else if (oh && blk_pos == 3'd0) begin
      mhist <= {mhist[0], rx_bit};
      if (mf_hit)
        mf_aligned <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_bit <= 1'b0;
      stuff <= '0;
      c1    <= 1'b0;
      c2    <= 1'b0;
    end else if (mf_aligned && oh) begin
      if (blk_pos == 3'd0 && sf_pos == SF_X)
        x_bit <= rx_bit;
      if (blk_pos == BLK_C1)
        c1 <= rx_bit;
      if (blk_pos == BLK_C2)
        c2 <= rx_bit;
      if (blk_pos == BLK_C3)
        stuff[sf_pos] <= (c1 & c2) | (c1 & rx_bit) | (c2 & rx_bit);
    end
  end
endmodule

// File: rtl/ds2_aligner_chk.sv
module ds2_aligner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] bit_pos,
  input logic [2:0] blk_pos,
  input logic [1:0] sf_pos,
  input logic       in_frame,
  input logic       mf_aligned,
  input logic       x_bit,
  input logic [3:0] stuff
);
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos < 6'd49 && blk_pos < 3'd6); // R1

  AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |=> !in_frame ||
      bit_pos == (($past(bit_pos) == 6'd48) ? 6'd0 : $past(bit_pos) + 6'd1)); // R4

  AST_SF_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_aligned && blk_pos == 3'd5 && bit_pos == 6'd48) |=>
      !mf_aligned || sf_pos == $past(sf_pos) + 2'd1); // R7

  AST_LOCK_AFTER_F: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> bit_pos == 6'd1 && (blk_pos == 3'd2 || blk_pos == 3'd5)); // R2

  AST_MF_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    mf_aligned |-> in_frame); // R10

  AST_STUFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_aligned |=> $stable(stuff) && $stable(x_bit)); // R10
endmodule

bind ds2_aligner ds2_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_pos(bit_pos), .blk_pos(blk_pos),
  .sf_pos(sf_pos), .in_frame(in_frame), .mf_aligned(mf_aligned),
  .x_bit(x_bit), .stuff(stuff)
);

// File: tb/ds2_aligner_tb.sv
module ds2_aligner_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0;
  logic [5:0] bit_pos;
  logic [2:0] blk_pos;
  logic [1:0] sf_pos;
  logic in_frame, mf_aligned, x_bit;
  logic [3:0] stuff;

  always #2.5 clk = ~clk;

  ds2_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_pos(bit_pos),
    .blk_pos(blk_pos), .sf_pos(sf_pos), .in_frame(in_frame),
    .mf_aligned(mf_aligned), .x_bit(x_bit), .stuff(stuff)
  );

  int nchk = 0, nerr = 0;
  int g_sf, g_blk, g_bit, cur_sf, cur_blk, cur_bit;
  logic xv, flip_f, was_f;
  logic [2:0] cpat [4];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic maj(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  task automatic step();
    logic b;
    @(negedge clk);
    rst_n = 1'b1;
    was_f = 1'b0;
    cur_sf = g_sf; cur_blk = g_blk; cur_bit = g_bit;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    b = lfsr[0];
    if (g_bit == 0) begin
      case (g_blk)
        0: b = (g_sf == 0) ? 1'b0 : (g_sf == 3) ? xv : 1'b1;
        1: b = cpat[g_sf][0];
        3: b = cpat[g_sf][1];
        4: b = cpat[g_sf][2];
        2: begin b = flip_f; was_f = 1'b1; flip_f = 1'b0; end
        default: begin b = ~flip_f; was_f = 1'b1; flip_f = 1'b0; end
      endcase
    end
    rx_bit = b;
    g_bit++;
    if (g_bit == 49) begin
      g_bit = 0; g_blk++;
      if (g_blk == 6) begin g_blk = 0; g_sf = (g_sf + 1) % 4; end
    end
    #1;
  endtask

  task automatic do_reset(input int s, input int k, input int b);
    @(negedge clk);
    rst_n = 1'b0;
    rx_bit = 1'b0;
    flip_f = 1'b0;
    repeat (3) @(negedge clk);
    g_sf = s; g_blk = k; g_bit = b;
  endtask

  task automatic run_to_f(input logic flip);
    flip_f = flip;
    was_f = 1'b0;
    while (!was_f) step();
  endtask

  task automatic wait_mf(input string req);
    int n = 0;
    while (!mf_aligned && n < 8000) begin step(); n++; end
    chk(mf_aligned, req, mf_aligned, 1);
  endtask

  task automatic track(input int n, input string req, input logic with_sf);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (bit_pos != cur_bit || blk_pos != cur_blk || (with_sf && sf_pos != cur_sf)) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0);
    #1;
    chk(bit_pos == 0 && blk_pos == 0 && sf_pos == 0, "R1 reset pos", {bit_pos, blk_pos, sf_pos}, 0);
    chk(!in_frame && !mf_aligned && !x_bit && stuff == 0, "R1 reset flags",
        {in_frame, mf_aligned, x_bit, stuff}, 0);
  endtask

  task automatic t_lock_aligned();
    for (int i = 0; i < 4; i++) cpat[i] = 3'b000;
    xv = 1'b0;
    do_reset(0, 0, 0);
    repeat (1422) step();
    chk(!in_frame, "R2 no lock before 10th F", in_frame, 0);
    step();
    chk(in_frame, "R2 lock after 10th F", in_frame, 1);
    chk(bit_pos == cur_bit && blk_pos == cur_blk, "R4 position at lock", bit_pos, cur_bit);
    track(300, "R1 R4 tracking", 1'b0);
    wait_mf("R7 multiframe lock X=0");
    track(2400, "R7 subframe tracking X=0", 1'b1);
  endtask

  task automatic t_search();
    xv = 1'b1;
    do_reset(3, 5, 44);
    begin
      int n = 0;
      while (!in_frame && n < 40000) begin step(); n++; end
    end
    chk(in_frame, "R3 search lock with offset", in_frame, 1);
    track(600, "R3 R4 position after search", 1'b0);
    wait_mf("R7 multiframe lock X=1");
    chk(sf_pos == cur_sf, "R7 subframe after lock X=1", sf_pos, cur_sf);
    track(1200, "R7 subframe tracking X=1", 1'b1);
  endtask

  task automatic t_stuff();
    logic [3:0] exp;
    cpat[0] = 3'b111; cpat[1] = 3'b110; cpat[2] = 3'b001; cpat[3] = 3'b100;
    xv = 1'b1;
    do_reset(0, 0, 0);
    wait_mf("R9 setup");
    repeat (1176) step();
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 4; i++) exp[i] = maj(cpat[i]);
      for (int i = 0; i < 1176; i++) begin
        step();
        if (cur_blk == 5 && cur_bit == 0)
          chk(stuff[cur_sf] == exp[cur_sf], "R9 stuff vote", stuff[cur_sf], exp[cur_sf]);
      end
      chk(x_bit == xv, "R8 x bit latch", x_bit, xv);
      for (int i = 0; i < 4; i++) cpat[i] = ~cpat[i];
      xv = ~xv;
      repeat (1176) step();
    end
  endtask

  task automatic t_lof();
    logic [3:0] s0;
    logic x0;
    cpat[0] = 3'b011; cpat[1] = 3'b000; cpat[2] = 3'b101; cpat[3] = 3'b001;
    xv = 1'b1;
    do_reset(0, 0, 0);
    wait_mf("R5 setup");
    repeat (1300) step();
    run_to_f(1'b1);
    step();
    chk(in_frame, "R5 single F error tolerated", in_frame, 1);
    repeat (4) run_to_f(1'b0);
    step();
    chk(in_frame && mf_aligned, "R5 still aligned", {in_frame, mf_aligned}, 3);
    s0 = stuff; x0 = x_bit;
    chk(s0 == 4'b0101 && x0, "R9 R8 state before loss", {x0, s0}, 5'b10101);
    run_to_f(1'b1);
    step();
    chk(in_frame, "R5 one error in window", in_frame, 1);
    run_to_f(1'b1);
    step();
    chk(!in_frame && !mf_aligned, "R5 loss of frame", {in_frame, mf_aligned}, 0);
    for (int i = 0; i < 4; i++) cpat[i] = ~cpat[i];
    xv = 1'b0;
    for (int i = 1; i <= 10; i++) begin
      run_to_f(1'b0);
      step();
      chk(in_frame == (i == 10), "R6 relock count", in_frame, i == 10);
    end
    chk(stuff == s0 && x_bit == x0, "R10 outputs held while unaligned", {x_bit, stuff}, {x0, s0});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) cpat[i] = 3'b000;
    xv = 1'b0;
    flip_f = 1'b0;
    g_sf = 0; g_blk = 0; g_bit = 0;
    t_reset();
    t_lock_aligned();
    t_search();
    t_stuff();
    t_lof();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule